// File: doc/BRIEF.md
# Byte UART Register Front End

This block sits between a simple synchronous word-addressed bus and the byte streams of a minimal serial port. Bytes from the receive side arrive over a valid/ready handshake and wait in an eight-deep queue. Software takes them out one at a time by reading the receive data word. A bus write to the transmit data word places its low byte in a one-byte holding stage, and that stage offers the byte downstream over another valid/ready handshake.

A status word reports queue occupancy, transmit holding state, a sticky event flag and three sticky error flags. The receive path feeds in the frame and parity error flags as plain pulse inputs. A control word can discard either direction's pending data and holds an interrupt enable. The level interrupt output is high when the event flag and the enable are both set.

Top module: `byte_uart_regs`

## Requirements
- R1: A read of word address 2 returns the status byte in bits 7:0, with zeros above. Bit 0 means the receive queue holds data, bit 1 that it holds 8 bytes, bit 2 that the transmit stage is empty, bit 3 that it holds a byte, bit 4 the event flag, bit 5 overrun, bit 6 frame error and bit 7 parity error. The frame and parity bits latch when `rx_frame_err` or `rx_parity_err` is high in a cycle.
- R2: A read of word address 0 returns the oldest queued byte in bits 7:0 and removes it from the queue. Bytes come out in arrival order. A read of address 0 while the queue is empty returns zero. Read data appears on `bus_rdata` in the cycle after the access and holds until the next read.
- R3: `rx_ready` is low exactly while 8 bytes are queued. A byte offered while the queue is full is dropped, the stored bytes are left unchanged, and the overrun bit is set.
- R4: `irq` equals the event flag ANDed with the interrupt enable, which is control bit 4.
- R5: A write to word address 1 loads its bits 7:0 into the transmit stage when that stage is empty. The byte is shown on `tx_byte` with `tx_valid` high until a cycle with `tx_ready` high. A write while the stage is full is discarded. Every write to address 1 sets the event flag.
- R6: A write to word address 3 with bit 1 set empties the receive queue and discards any byte offered in that cycle. A write with bit 0 set empties the transmit stage.
- R7: A status read clears the event, overrun, frame and parity bits. A byte accepted into the queue sets the event flag. When a set and a clear fall in the same cycle, the set wins.
- R8: Writes to word address 2 change nothing.
- R9: A read of word address 3 returns the enable in bit 4 and zeros elsewhere. Reads of address 1 and of addresses 4 and up return zero. Writes to addresses 4 and up change nothing.
- R10: After reset the status reads 0x04, the queue is empty, `irq` and `tx_valid` are low and `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt |
| rx_byte | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte offered |
| rx_ready | output | 1 | Queue can take a byte |
| rx_frame_err | input | 1 | Frame error pulse from the receiver |
| rx_parity_err | input | 1 | Parity error pulse from the receiver |
| tx_byte | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte held |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
The queue assertions assume that the top only pushes when there is room and only pops when there is data. The handshake gating is what guarantees this, so the bench is free to hold `rx_valid` high against a full queue, and it does so on purpose. The transmit hold check assumes `tx_ready` may drop at any time; the random phase toggles it freely. The random phase also mixes reads, writes and address values so that it reaches illegal addresses, same-cycle set-and-clear of the sticky flags, and control writes that flush a direction while traffic is arriving.

// File: rtl/ubr_pkg.sv
package ubr_pkg;
  // status bit positions (software decodes these)
  localparam int ST_RXV  = 0;
  localparam int ST_RXF  = 1;
  localparam int ST_TXE  = 2;
  localparam int ST_TXF  = 3;
  localparam int ST_PEND = 4;
  localparam int ST_OVR  = 5;
  localparam int ST_FRM  = 6;
  localparam int ST_PAR  = 7;
  // control bit positions
  localparam int CT_TXRST = 0;
  localparam int CT_RXRST = 1;
  localparam int CT_IE    = 4;

  typedef enum logic [1:0] {
    A_RXD  = 2'd0,
    A_TXD  = 2'd1,
    A_STAT = 2'd2,
    A_CTRL = 2'd3
  } reg_sel_e;

  // packed MSB first: par is bit 7, rxv is bit 0
  typedef struct packed {
    logic par;
    logic frm;
    logic ovr;
    logic pend;
    logic txf;
    logic txe;
    logic rxf;
    logic rxv;
  } stat_t;
endpackage

// File: rtl/ubr_rx_fifo.sv
module ubr_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  input  logic                         flush,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wpos;
  logic [CW-1:0] len;

  // oldest slot = write position minus length, wrapped (DEPTH is a power of two)
  function automatic logic [PW-1:0] oldest(input logic [PW-1:0] p, input logic [CW-1:0] l);
    return p - PW'(l);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wpos <= '0;
      len  <= '0;
    end else if (flush) begin
      wpos <= '0;
      len  <= '0;
    end else begin
      if (push) wpos <= wpos + 1'b1;
      len <= len + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wpos] <= din;
  end

  assign head  = mem[oldest(wpos, len)];
  assign count = len;
  assign full  = (len == CW'(DEPTH));
  assign empty = (len == '0);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) full |-> !push);
  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) empty |-> !pop);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && push && !pop) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/ubr_tx_hold.sv
module ubr_tx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         flush,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (flush) begin
      valid <= 1'b0;
    end else if (load && !valid) begin
      valid <= 1'b1;
      data  <= din;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !flush) |=> (valid && $stable(data)));
endmodule

// File: rtl/ubr_flags.sv
module ubr_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [N-1:0] set,
  output logic [N-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= set | (q & ~{N{clear}});
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n) set[i] |=> q[i]);
    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !set[i]) |=> !q[i]);
  end
endmodule

// File: rtl/byte_uart_regs.sv
module byte_uart_regs
  import ubr_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int RX_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic [7:0]        rx_byte,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_frame_err,
  input  logic              rx_parity_err,
  output logic [7:0]        tx_byte,
  output logic              tx_valid,
  input  logic              tx_ready
);
  localparam int CW = $clog2(RX_DEPTH + 1);

  // decoded access events, named for the checkers
  logic     rd_stb, wr_stb, in_range;
  reg_sel_e sel;
  assign in_range = (bus_addr[ADDR_W-1:2] == '0);
  assign sel      = reg_sel_e'(bus_addr[1:0]);
  assign rd_stb   = bus_en && !bus_we && in_range;
  assign wr_stb   = bus_en &&  bus_we && in_range;

  logic stat_rd, ctrl_wr, txd_wr, rx_flush, tx_flush;
  assign stat_rd  = rd_stb && (sel == A_STAT);
  assign ctrl_wr  = wr_stb && (sel == A_CTRL);
  assign txd_wr   = wr_stb && (sel == A_TXD);
  assign rx_flush = ctrl_wr && bus_wdata[CT_RXRST];
  assign tx_flush = ctrl_wr && bus_wdata[CT_TXRST];

  // receive queue
  logic          fifo_full, fifo_empty;
  logic [7:0]    fifo_head;
  logic [CW-1:0] fifo_count;
  logic          rx_accept, rx_drop, rx_pop;
  assign rx_ready  = !fifo_full;
  assign rx_accept = rx_valid && !fifo_full && !rx_flush;
  assign rx_drop   = rx_valid && fifo_full;
  assign rx_pop    = rd_stb && (sel == A_RXD) && !fifo_empty;

  ubr_rx_fifo #(.DEPTH(RX_DEPTH), .W(8)) u_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_accept),
    .din   (rx_byte),
    .pop   (rx_pop),
    .flush (rx_flush),
    .head  (fifo_head),
    .count (fifo_count),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  // transmit holding stage
  ubr_tx_hold #(.W(8)) u_tx_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (txd_wr),
    .din   (bus_wdata[7:0]),
    .flush (tx_flush),
    .ready (tx_ready),
    .valid (tx_valid),
    .data  (tx_byte)
  );

  // sticky flags: [0] event, [1] overrun, [2] frame, [3] parity
  logic [3:0] flag_set, flag_q;
  assign flag_set = {rx_parity_err, rx_frame_err, rx_drop, rx_accept || txd_wr};

  ubr_flags #(.N(4)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (stat_rd),
    .set   (flag_set),
    .q     (flag_q)
  );

  // control: only the enable is stored, the flush bits act and vanish
  logic irq_en;
  always_ff @(posedge clk) begin
    if (!rst_n)       irq_en <= 1'b0;
    else if (ctrl_wr) irq_en <= bus_wdata[CT_IE];
  end

  stat_t status;
  always_comb begin
    status      = '0;
    status.rxv  = !fifo_empty;
    status.rxf  = fifo_full;
    status.txe  = !tx_valid;
    status.txf  = tx_valid;
    status.pend = flag_q[0];
    status.ovr  = flag_q[1];
    status.frm  = flag_q[2];
    status.par  = flag_q[3];
  end

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (in_range) begin
      unique case (sel)
        A_RXD:   rd_next = fifo_empty ? '0 : DATA_W'(fifo_head);
        A_STAT:  rd_next = DATA_W'(status);
        A_CTRL:  rd_next = DATA_W'(irq_en) << CT_IE;
        default: rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   bus_rdata <= '0;
    else if (bus_en && !bus_we)   bus_rdata <= rd_next;
  end

  assign irq = flag_q[0] && irq_en;

  // R3
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> status.ovr);
  // R6
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (fifo_count == '0));
  // R8
  stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && sel == A_STAT) |=> $stable(irq_en));
endmodule

// File: tb/byte_uart_regs_bench.sv
module byte_uart_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic        rx_frame_err = 1'b0, rx_parity_err = 1'b0;
  logic [7:0]  tx_byte;
  logic        tx_valid;
  logic        tx_ready = 1'b0;

  int errors = 0;
  int checks = 0;
  string rd_tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_uart_regs u_byte_uart_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  byte         q[$];
  bit          m_pend, m_ovr, m_frm, m_par, m_ie, m_txv;
  logic [7:0]  m_txd;
  logic [31:0] m_rd;
  string       m_tag = "R10";

  function automatic logic [31:0] m_status();
    return {24'h0, m_par, m_frm, m_ovr, m_pend, m_txv, !m_txv,
            q.size() == 8, q.size() != 0};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      {m_pend, m_ovr, m_frm, m_par, m_ie, m_txv} = '0;
      m_txd = '0;
      m_rd = '0;
    end else begin
      bit full_pre, srd, rxrst, txrst, accept, twr, txv_pre;
      logic [31:0] st;
      full_pre = (q.size() == 8);
      st       = m_status();
      txv_pre  = m_txv;
      srd = bus_en && !bus_we && bus_addr == 2;
      twr = bus_en && bus_we && bus_addr == 1;
      rxrst = bus_en && bus_we && bus_addr == 3 && bus_wdata[1];
      txrst = bus_en && bus_we && bus_addr == 3 && bus_wdata[0];
      if (bus_en && !bus_we) begin
        m_tag = rd_tag;
        case (bus_addr)
          4'd0: m_rd = (q.size() > 0) ? {24'h0, q.pop_front()} : 32'h0;
          4'd2: m_rd = st;
          4'd3: m_rd = {27'h0, m_ie, 4'h0};
          default: m_rd = 32'h0;
        endcase
      end
      accept = rx_valid && !full_pre && !rxrst;
      if (rxrst) q.delete();
      if (accept) q.push_back(rx_byte);
      m_pend = (m_pend && !srd) || accept || twr;
      m_ovr  = (m_ovr && !srd) || (rx_valid && full_pre);
      m_frm  = (m_frm && !srd) || rx_frame_err;
      m_par  = (m_par && !srd) || rx_parity_err;
      if (bus_en && bus_we && bus_addr == 3) m_ie = bus_wdata[4];
      if (txrst) m_txv = 1'b0;
      else if (twr && !txv_pre) begin m_txv = 1'b1; m_txd = bus_wdata[7:0]; end
      else if (m_txv && tx_ready) m_txv = 1'b0;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      check(irq == 1'b0 && tx_valid == 1'b0 && rx_ready == 1'b1, "R10",
            {29'h0, irq, tx_valid, rx_ready}, 32'h1);
    end else begin
      check(bus_rdata == m_rd, m_tag, bus_rdata, m_rd);
      check(irq == (m_pend && m_ie), "R4", irq, m_pend && m_ie);
      check(rx_ready == (q.size() < 8), "R3", rx_ready, q.size() < 8);
      check(tx_valid == m_txv, "R5", tx_valid, m_txv);
      if (m_txv) check(tx_byte == m_txd, "R5", tx_byte, m_txd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic bus_rd(input logic [3:0] a, input string tag);
    bus_en = 1; bus_we = 0; bus_addr = a; rd_tag = tag;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic rd_expect(input logic [3:0] a, input logic [31:0] exp, input string tag);
    bus_rd(a, tag);
    check(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1; rx_byte = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset status
    rd_expect(4'd2, 32'h04, "R10");
    // R2 ordering
    push(8'hA1); push(8'hB2); push(8'hC3);
    rd_expect(4'd0, 32'hA1, "R2");
    rd_expect(4'd2, 32'h15, "R7");
    rd_expect(4'd2, 32'h05, "R7");
    rd_expect(4'd0, 32'hB2, "R2");
    rd_expect(4'd0, 32'hC3, "R2");
    rd_expect(4'd0, 32'h00, "R2");
    // R3 full queue drops
    for (int i = 0; i < 8; i++) push(8'h10 + 8'(i));
    check(rx_ready == 1'b0, "R3", rx_ready, 0);
    push(8'hEE);
    rd_expect(4'd2, 32'h37, "R3");
    rd_expect(4'd0, 32'h10, "R3");
    for (int i = 1; i < 8; i++) rd_expect(4'd0, 32'h10 + i, "R2");
    // R8 status write ignored
    bus_wr(4'd2, 32'hFF);
    rd_expect(4'd2, 32'h04, "R8");
    // R6 receive flush
    push(8'h01); push(8'h02); push(8'h03);
    bus_wr(4'd3, 32'h02);
    rd_expect(4'd2, 32'h14, "R6");
    rd_expect(4'd0, 32'h00, "R6");
    // R5 transmit path
    tx_ready = 0;
    bus_wr(4'd1, 32'h123456A5);
    check(tx_valid && tx_byte == 8'hA5, "R5", tx_byte, 32'hA5);
    bus_wr(4'd1, 32'h77);
    check(tx_valid && tx_byte == 8'hA5, "R5", tx_byte, 32'hA5);
    rd_expect(4'd2, 32'h18, "R1");
    bus_wr(4'd3, 32'h01);
    check(tx_valid == 1'b0, "R6", tx_valid, 0);
    bus_wr(4'd1, 32'h3C);
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
    check(tx_valid == 1'b0, "R5", tx_valid, 0);
    // R4 interrupt
    bus_wr(4'd3, 32'h10);
    rd_expect(4'd3, 32'h10, "R9");
    check(irq == 1'b1, "R4", irq, 1);
    rd_expect(4'd2, 32'h14, "R1");
    check(irq == 1'b0, "R4", irq, 0);
    // R1 sticky error inputs
    rx_frame_err = 1; @(negedge clk); rx_frame_err = 0;
    rx_parity_err = 1; @(negedge clk); rx_parity_err = 0;
    rd_expect(4'd2, 32'hC4, "R1");
    rd_expect(4'd2, 32'h04, "R7");
    // R9 address range
    rd_expect(4'd5, 32'h0, "R9");
    rd_expect(4'd1, 32'h0, "R9");
    bus_wr(4'd7, 32'h02);
    rd_expect(4'd3, 32'h10, "R9");
    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      rx_valid      = ($urandom_range(1) == 1);
      rx_byte       = 8'($urandom);
      tx_ready      = ($urandom_range(1) == 1);
      rx_frame_err  = ($urandom_range(19) == 0);
      rx_parity_err = ($urandom_range(19) == 0);
      bus_en        = ($urandom_range(9) < 4);
      bus_we        = ($urandom_range(3) == 0);
      bus_addr      = 4'($urandom_range(7));
      bus_wdata     = $urandom;
      case (bus_addr)
        4'd0: rd_tag = "R2";
        4'd2: rd_tag = "R1";
        4'd3: rd_tag = "R4";
        default: rd_tag = "R9";
      endcase
      @(negedge clk);
    end
    bus_en = 0; rx_valid = 0;
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule